// File: doc/BRIEF.md
# Store Buffer with Fence Support

This block sits between a processor's store path and its data cache. A retiring store hands over a word address and a value. The block takes them in one cycle, and the processor moves on without waiting for the cache. Held stores leave from the oldest end through a valid/ready write port toward the cache. They leave strictly in the order they arrived, and this happens in the background while the processor keeps issuing.

Loads must see stores that have not yet reached the cache. For this, the block compares every held address against the load address in parallel. The value returned comes from the most recently accepted matching entry. When the processor raises a fence request, the block holds a stall output high until every held store has been written out. A full buffer refuses new stores until an entry drains.

Top module: `store_buffer`

## Requirements
- R1: After reset the buffer holds no entries: `sb_empty` is 1, `cw_valid` is 0, `st_ready` is 1, `ld_hit` is 0 and `fence_stall` is 0.
- R2: A store is accepted at a rising edge where `st_valid` and `st_ready` are both 1. Accepted stores appear on `cw_addr`/`cw_data` one at a time, in acceptance order, each exactly once. A store accepted at an edge is first visible from the following cycle.
- R3: While `cw_valid` is 1 and `cw_ready` is 0, the head entry stays in place: `cw_valid`, `cw_addr` and `cw_data` hold their values in the next cycle.
- R4: `st_ready` is 0 exactly when 8 entries are held. A store offered then is not taken. Readiness returns in the cycle after a cache write handshake.
- R5: `ld_hit` is 1 when any held entry's address equals `ld_addr`. In that case `ld_data` is the value of the most recently accepted matching entry. Otherwise `ld_hit` is 0.
- R6: `fence_stall` equals `fence_req` AND the buffer holding at least one entry.
- R7: `sb_empty` is 1 exactly when no entry is held, and `cw_valid` is then 0.
- R8: Once an entry has drained through a handshake, it no longer takes part in the load search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered by the processor |
| st_addr | input | AW | Word address of the store |
| st_data | input | DW | Store value |
| st_ready | output | 1 | Buffer can accept a store |
| ld_addr | input | AW | Load word address to search |
| ld_hit | output | 1 | A held entry matches `ld_addr` |
| ld_data | output | DW | Value of the youngest matching entry |
| fence_req | input | 1 | Processor requests a fence |
| fence_stall | output | 1 | Processor must wait for the fence |
| cw_valid | output | 1 | Cache write offered |
| cw_addr | output | AW | Cache write address (oldest entry) |
| cw_data | output | DW | Cache write value (oldest entry) |
| cw_ready | input | 1 | Cache accepts the write |
| sb_empty | output | 1 | No entries held |

## Verification
The hardest case to reach is a full buffer whose entries repeat a few addresses, so that a load must choose the youngest of several matches. The difficulty is that the cache keeps draining and the buffer rarely fills. To get there, the stimulus holds `cw_ready` low while stores are issued, with addresses drawn from only eight values. It then releases the cache gradually with a random ready pattern, so that forwarding, drain order and the full-to-not-full step are all observed while matches are being removed.

// File: rtl/store_buffer.sv
module store_buffer #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          st_ready,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  input  logic          fence_req,
  output logic          fence_stall,
  output logic          cw_valid,
  output logic [AW-1:0] cw_addr,
  output logic [DW-1:0] cw_data,
  input  logic          cw_ready,
  output logic          sb_empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;

  wire push = st_valid && st_ready;
  wire pop  = cw_valid && cw_ready;

  assign sb_empty    = (count == '0);
  assign st_ready    = (count != CW'(DEPTH));
  assign cw_valid    = !sb_empty;
  assign cw_addr     = addr_q[head];
  assign cw_data     = data_q[head];
  assign fence_stall = fence_req && !sb_empty;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        addr_q[tail] <= st_addr;
        data_q[tail] <= st_data;
        tail         <= nxt(tail);
      end
      if (pop) head <= nxt(head);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    logic [PW:0] s;
    ld_hit  = 1'b0;
    ld_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      s = {1'b0, head} + (PW+1)'(i);
      if (s >= (PW+1)'(DEPTH)) s = s - (PW+1)'(DEPTH);
      if (CW'(i) < count && addr_q[s[PW-1:0]] == ld_addr) begin
        ld_hit  = 1'b1;
        ld_data = data_q[s[PW-1:0]];
      end
    end
  end
endmodule

module store_buffer_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_ready,
  input logic          ld_hit,
  input logic          fence_req,
  input logic          fence_stall,
  input logic          cw_valid,
  input logic [AW-1:0] cw_addr,
  input logic [DW-1:0] cw_data,
  input logic          cw_ready,
  input logic          sb_empty,
  input logic [CW-1:0] count
);
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid && !cw_ready |=> cw_valid && $stable(cw_addr) && $stable(cw_data)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R4
  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |-> !sb_empty); // R4
  AST_HIT_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> !sb_empty); // R5
  AST_FENCE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    fence_req && sb_empty |-> !fence_stall); // R6
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sb_empty |-> !cw_valid); // R7
endmodule

bind store_buffer store_buffer_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_ready(st_ready), .ld_hit(ld_hit),
  .fence_req(fence_req), .fence_stall(fence_stall), .cw_valid(cw_valid),
  .cw_addr(cw_addr), .cw_data(cw_data), .cw_ready(cw_ready),
  .sb_empty(sb_empty), .count(count));

// File: tb/store_buffer_tb.sv
module store_buffer_tb;
  localparam int AW = 32, DW = 32, DEPTH = 8;
  logic clk = 0, rst_n = 0;
  logic st_valid = 0, fence_req = 0, cw_ready = 0;
  logic [AW-1:0] st_addr = 0, ld_addr = 0;
  logic [DW-1:0] st_data = 0;
  logic st_ready, ld_hit, fence_stall, cw_valid, sb_empty;
  logic [DW-1:0] ld_data, cw_data;
  logic [AW-1:0] cw_addr;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [AW-1:0] qa[$];
  logic [DW-1:0] qd[$];

  always #2 clk = ~clk;

  store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_hit(input logic [AW-1:0] a);
    foreach (qa[i]) if (qa[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [DW-1:0] exp_data(input logic [AW-1:0] a);
    for (int i = qa.size() - 1; i >= 0; i--) if (qa[i] == a) return qd[i];
    return '0;
  endfunction

  // inputs already set at negedge; check outputs, then advance model at the edge
  task automatic cyc();
    logic push, pop;
    #1;
    chk("R7 empty", sb_empty, qa.size() == 0);
    chk("R4 ready", st_ready, qa.size() < DEPTH);
    chk("R6 fence", fence_stall, fence_req && qa.size() != 0);
    chk("R5 hit", ld_hit, exp_hit(ld_addr));
    if (exp_hit(ld_addr)) chk("R5 youngest data", ld_data, exp_data(ld_addr));
    chk("R2 cw_valid", cw_valid, qa.size() != 0);
    if (qa.size() != 0) begin
      chk("R2 drain addr", cw_addr, qa[0]);
      chk("R2 drain data", cw_data, qd[0]);
    end
    push = st_valid && (qa.size() < DEPTH);
    pop  = cw_ready && (qa.size() != 0);
    @(posedge clk);
    if (pop) begin void'(qa.pop_front()); void'(qd.pop_front()); end
    if (push) begin qa.push_back(st_addr); qd.push_back(st_data); end
    @(negedge clk);
  endtask

  initial begin
    int n;
    void'($urandom(32'h5B0F));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 empty", sb_empty, 1); chk("R1 cw_valid", cw_valid, 0);
    chk("R1 st_ready", st_ready, 1); chk("R1 ld_hit", ld_hit, 0);
    chk("R1 fence_stall", fence_stall, 0);
    @(negedge clk);
    // fill to full with cache stalled, repeated addresses (R4, R5, R3)
    cw_ready = 0;
    for (int i = 0; i < 10; i++) begin
      st_valid = 1; st_addr = 32'(i % 3); st_data = 32'hA0 + 32'(i);
      ld_addr = 32'(i % 3); cyc();
    end
    st_valid = 0;
    for (int a = 0; a < 4; a++) begin ld_addr = 32'(a); cyc(); end
    // one drain frees a slot (R4) and removes it from the search (R8)
    cw_ready = 1; ld_addr = 0; cyc();
    cw_ready = 0; st_valid = 1; st_addr = 7; st_data = 32'h77; cyc();
    st_valid = 0; ld_addr = 7; cyc();
    // fence: stall until drained (R6)
    fence_req = 1; cw_ready = 1;
    n = 0;
    while (qa.size() != 0 && n < 20) begin ld_addr = 32'(n % 8); cyc(); n++; end
    cyc();
    chk("R6 fence released", fence_stall, 0);
    chk("R8 drained miss", ld_hit, 0);
    fence_req = 0;
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      st_valid  = ($urandom % 3) != 0;
      st_addr   = 32'($urandom % 8);
      st_data   = $urandom;
      ld_addr   = 32'($urandom % 8);
      cw_ready  = (k % 600 < 300) ? (($urandom % 5) == 0) : (($urandom % 3) != 0);
      fence_req = ($urandom % 10) == 0;
      cyc();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule